// File: doc/BRIEF.md
# Chained descriptor DMA fetcher

This block walks a linked list of four-word descriptors in memory and moves data between the buffers those descriptors name and a 32-bit stream. A start pulse makes it read the first descriptor at the base address it is given. It checks that the descriptor is handed to the engine, transfers one or two buffers, and returns the descriptor to software by writing word 0 back with the ownership bit cleared. It then follows either the explicit next pointer or the sequential/ring rule.

A total byte count limits how much data the list may move, so the final buffer can be shorter than its descriptor says. The memory side is a single request/acknowledge word port, shared between descriptor traffic and data traffic. The data side is a valid/ready stream whose direction is chosen when the transfer starts. Status is reported as one-cycle completion and interrupt pulses, and as a sticky flag for a descriptor that software has not handed over.

Top module: `ddma_chain_dma`

## Requirements
- R1: While rst_ni is low, and after it is released, busy_o, done_o, irq_o, unavail_o, mem_req_o, out_valid_o and in_ready_o are all 0.
- R2: A start_i pulse while enable_i is low is ignored: no memory request is made and busy_o stays 0.
- R3: An accepted start reads descriptor words at base_addr_i, +4, +8, +12 in that order. Every memory request keeps its address, write enable and write data steady until mem_ack_i.
- R4: If word 0 bit 31 (engine owns the descriptor) is clear, the engine fetches nothing more of that descriptor. It moves no data, writes nothing back, sets unavail_o and goes idle. unavail_o holds until the next accepted start or a soft reset.
- R5: With word 0 bit 4 (chained) set, only one buffer is moved: word 1 bits 12:0 bytes at the address in word 2. The next descriptor is read from the address in word 3.
- R6: With bit 4 clear, the first buffer is moved as in R5, then a second buffer of word 1 bits 25:13 bytes at the address in word 3. The next descriptor is at the current descriptor address + 16, or at the base address when word 0 bit 5 (ring end) is set.
- R7: Each buffer moves min(size, remaining) bytes, rounded up to whole 32-bit words at consecutive addresses. The remaining count starts at total_bytes_i and drops by the bytes granted to each buffer.
- R8: After its buffers, each descriptor's word 0 is written back to the descriptor address with bit 31 cleared and all other bits unchanged.
- R9: irq_o pulses for one cycle, in the cycle after the acknowledge, after each write-back whose word 0 bit 1 (interrupt disable) is clear. It does not pulse when that bit is set.
- R10: done_o pulses for one cycle and busy_o falls after the write-back of a descriptor whose word 0 bit 2 (last) is set, or after one that leaves the remaining count at zero. No further descriptor is fetched.
- R11: dir_i is latched at start. With 0, memory words appear on the out stream in address order. With 1, in-stream words are written to memory in arrival order.
- R12: soft_rst_i high at a clock edge leaves the engine idle in the next cycle, with no memory request, no stream handshake and unavail_o cleared.
- R13: While out_valid_o is high and out_ready_i is low, out_valid_o and out_data_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Engine enable; start is accepted only when high |
| soft_rst_i | input | 1 | Synchronous engine reset |
| start_i | input | 1 | Start walking the list (one-cycle pulse) |
| dir_i | input | 1 | 0: memory to out stream, 1: in stream to memory |
| base_addr_i | input | AW | Address of the first descriptor |
| total_bytes_i | input | CNT_W | Total byte limit for the transfer |
| busy_o | output | 1 | Engine is walking the list |
| done_o | output | 1 | Transfer complete pulse |
| irq_o | output | 1 | Per-descriptor completion interrupt pulse |
| unavail_o | output | 1 | Stopped on a descriptor not owned by the engine |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Access complete; read data valid with it |
| mem_rdata_i | input | 32 | Memory read data |
| out_valid_o | output | 1 | Out stream valid |
| out_ready_i | input | 1 | Out stream ready |
| out_data_o | output | 32 | Out stream data |
| in_valid_i | input | 1 | In stream valid |
| in_ready_o | output | 1 | In stream ready |
| in_data_i | input | 32 | In stream data |

## Verification
The write-back of the descriptor marked last raises the per-descriptor interrupt and the end-of-transfer pulse in the same cycle, because both hang on one acknowledge. The bench builds a chain whose final entry has its interrupt-disable flag clear, counts the cycles in which irq_o and done_o are high together, and expects exactly one such cycle. The ring case also makes the ring-end rule and the ownership check meet: the engine returns to the base descriptor, whose ownership it has just cleared, so the fetch must stop with unavail_o rather than loop.

// File: rtl/ddma_pkg.sv
package ddma_pkg;
  localparam int unsigned SZ_W       = 13;  // buffer size field width
  localparam int unsigned F_DIC      = 1;
  localparam int unsigned F_LAST     = 2;
  localparam int unsigned F_CHAIN    = 4;
  localparam int unsigned F_RING_END = 5;
  localparam int unsigned F_OWN      = 31;

  typedef enum logic [2:0] {
    C_IDLE, C_FETCH, C_B1_GO, C_B1_WAIT, C_B2_GO, C_B2_WAIT, C_WBACK
  } ctl_st_e;

  typedef enum logic [2:0] {
    M_IDLE, M_RD, M_PUSH, M_PULL, M_WR
  } mv_st_e;
endpackage

// File: rtl/ddma_clip.sv
module ddma_clip import ddma_pkg::*; #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned WD_W  = SZ_W - 1
) (
  input  logic [SZ_W-1:0]  size_i,
  input  logic [CNT_W-1:0] remain_i,
  output logic [CNT_W-1:0] bytes_o,
  output logic [WD_W-1:0]  words_o
);
  logic [CNT_W-1:0] size_ext;
  logic [SZ_W:0]    rnd;

  always_comb begin
    size_ext = {{(CNT_W-SZ_W){1'b0}}, size_i};
    bytes_o  = (remain_i < size_ext) ? remain_i : size_ext;
    // bytes_o never exceeds size_i, so the low SZ_W bits carry it fully
    rnd      = {1'b0, bytes_o[SZ_W-1:0]} + (SZ_W+1)'(3);
    words_o  = rnd[SZ_W:2];
  end
endmodule

// File: rtl/ddma_next.sv
module ddma_next #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          chain_i,
  input  logic          ring_end_i,
  output logic [AW-1:0] nxt_o
);
  localparam logic [AW-1:0] DESC_BYTES = AW'(16);

  always_comb begin
    if (chain_i)         nxt_o = ptr_i;
    else if (ring_end_i) nxt_o = base_i;
    else                 nxt_o = cur_i + DESC_BYTES;
  end
endmodule

// File: rtl/ddma_mover.sv
module ddma_mover import ddma_pkg::*; #(
  parameter int unsigned AW   = 32,
  parameter int unsigned WD_W = SZ_W - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic            go_i,
  input  logic            dir_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [WD_W-1:0] words_i,
  output logic            done_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [31:0]     mem_rdata_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [31:0]     out_data_o,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [31:0]     in_data_i
);
  localparam logic [AW-1:0]   STEP = AW'(4);
  localparam logic [WD_W-1:0] ONE  = WD_W'(1);

  mv_st_e          st_q;
  logic [AW-1:0]   addr_q;
  logic [WD_W-1:0] cnt_q;
  logic [31:0]     hold_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= M_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      done_q <= 1'b0;
    end else if (soft_rst_i) begin
      st_q   <= M_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        M_IDLE: if (go_i) begin
          addr_q <= addr_i;
          cnt_q  <= words_i;
          if (words_i == '0) done_q <= 1'b1;
          else               st_q   <= dir_i ? M_PULL : M_RD;
        end
        M_RD: if (mem_ack_i) begin
          hold_q <= mem_rdata_i;
          st_q   <= M_PUSH;
        end
        M_PUSH: if (out_ready_i) begin
          addr_q <= addr_q + STEP;
          cnt_q  <= cnt_q - ONE;
          if (cnt_q == ONE) begin
            done_q <= 1'b1;
            st_q   <= M_IDLE;
          end else st_q <= M_RD;
        end
        M_PULL: if (in_valid_i) begin
          hold_q <= in_data_i;
          st_q   <= M_WR;
        end
        M_WR: if (mem_ack_i) begin
          addr_q <= addr_q + STEP;
          cnt_q  <= cnt_q - ONE;
          if (cnt_q == ONE) begin
            done_q <= 1'b1;
            st_q   <= M_IDLE;
          end else st_q <= M_PULL;
        end
        default: st_q <= M_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign mem_req_o   = (st_q == M_RD) || (st_q == M_WR);
  assign mem_we_o    = (st_q == M_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = hold_q;
  assign out_valid_o = (st_q == M_PUSH);
  assign out_data_o  = hold_q;
  assign in_ready_o  = (st_q == M_PULL);

  // R13: stalled out-stream word stays put
  a_r13_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R3: data request steady until acknowledged
  a_r3_data_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));
endmodule

// File: rtl/ddma_chain_dma.sv
module ddma_chain_dma import ddma_pkg::*; #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             soft_rst_i,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic [CNT_W-1:0] total_bytes_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o,
  output logic             unavail_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [31:0]      out_data_o,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [31:0]      in_data_i
);
  localparam int unsigned WD_W = SZ_W - 1;

  ctl_st_e          st_q;
  logic [AW-1:0]    cur_q, base_q, a2_q, a3_q;
  logic [1:0]       idx_q;
  logic [31:0]      w0_q;
  logic [SZ_W-1:0]  sz1_q, sz2_q;
  logic [CNT_W-1:0] remain_q;
  logic             dir_q, done_q, irq_q, unav_q;

  logic             sel_b2;
  logic [SZ_W-1:0]  clip_size;
  logic [CNT_W-1:0] clip_bytes;
  logic [WD_W-1:0]  clip_words;
  logic             mv_go, mv_done, mv_req, mv_we;
  logic [AW-1:0]    mv_addr_in, mv_addr, nxt_addr;
  logic [31:0]      mv_wdata;
  logic             ctl_req, ctl_we;
  logic [AW-1:0]    ctl_addr;
  logic [31:0]      ctl_wdata;

  assign sel_b2     = (st_q == C_B2_GO) || (st_q == C_B2_WAIT);
  assign clip_size  = sel_b2 ? sz2_q : sz1_q;
  assign mv_go      = (st_q == C_B1_GO) || (st_q == C_B2_GO);
  assign mv_addr_in = sel_b2 ? a3_q : a2_q;

  ddma_clip #(.CNT_W(CNT_W), .WD_W(WD_W)) u_clip (
    .size_i   (clip_size),
    .remain_i (remain_q),
    .bytes_o  (clip_bytes),
    .words_o  (clip_words)
  );

  ddma_next #(.AW(AW)) u_next (
    .cur_i      (cur_q),
    .base_i     (base_q),
    .ptr_i      (a3_q),
    .chain_i    (w0_q[F_CHAIN]),
    .ring_end_i (w0_q[F_RING_END]),
    .nxt_o      (nxt_addr)
  );

  ddma_mover #(.AW(AW), .WD_W(WD_W)) u_mover (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .go_i        (mv_go),
    .dir_i       (dir_q),
    .addr_i      (mv_addr_in),
    .words_i     (clip_words),
    .done_o      (mv_done),
    .mem_req_o   (mv_req),
    .mem_we_o    (mv_we),
    .mem_addr_o  (mv_addr),
    .mem_wdata_o (mv_wdata),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i)
  );

  always_comb begin
    ctl_req   = (st_q == C_FETCH) || (st_q == C_WBACK);
    ctl_we    = (st_q == C_WBACK);
    ctl_addr  = (st_q == C_WBACK) ? cur_q
                                  : cur_q + {{(AW-4){1'b0}}, idx_q, 2'b00};
    ctl_wdata = w0_q & ~(32'd1 << F_OWN);
  end

  // descriptor and data phases never overlap, so the port is a plain mux
  assign mem_req_o   = ctl_req | mv_req;
  assign mem_we_o    = ctl_req ? ctl_we    : mv_we;
  assign mem_addr_o  = ctl_req ? ctl_addr  : mv_addr;
  assign mem_wdata_o = ctl_req ? ctl_wdata : mv_wdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= C_IDLE;
      cur_q    <= '0;
      base_q   <= '0;
      a2_q     <= '0;
      a3_q     <= '0;
      idx_q    <= '0;
      w0_q     <= '0;
      sz1_q    <= '0;
      sz2_q    <= '0;
      remain_q <= '0;
      dir_q    <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      unav_q   <= 1'b0;
    end else if (soft_rst_i) begin
      st_q   <= C_IDLE;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      unav_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      unique case (st_q)
        C_IDLE: if (start_i && enable_i) begin
          cur_q    <= base_addr_i;
          base_q   <= base_addr_i;
          remain_q <= total_bytes_i;
          dir_q    <= dir_i;
          idx_q    <= '0;
          unav_q   <= 1'b0;
          st_q     <= C_FETCH;
        end
        C_FETCH: if (mem_ack_i) begin
          unique case (idx_q)
            2'd0: w0_q <= mem_rdata_i;
            2'd1: begin
              sz1_q <= mem_rdata_i[SZ_W-1:0];
              sz2_q <= mem_rdata_i[2*SZ_W-1:SZ_W];
            end
            2'd2: a2_q <= mem_rdata_i[AW-1:0];
            default: a3_q <= mem_rdata_i[AW-1:0];
          endcase
          if (idx_q == 2'd0 && !mem_rdata_i[F_OWN]) begin
            unav_q <= 1'b1;
            st_q   <= C_IDLE;
          end else if (idx_q == 2'd3) begin
            st_q <= C_B1_GO;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        C_B1_GO: begin
          remain_q <= remain_q - clip_bytes;
          st_q     <= C_B1_WAIT;
        end
        C_B1_WAIT: if (mv_done) st_q <= w0_q[F_CHAIN] ? C_WBACK : C_B2_GO;
        C_B2_GO: begin
          remain_q <= remain_q - clip_bytes;
          st_q     <= C_B2_WAIT;
        end
        C_B2_WAIT: if (mv_done) st_q <= C_WBACK;
        C_WBACK: if (mem_ack_i) begin
          irq_q <= !w0_q[F_DIC];
          if (w0_q[F_LAST] || remain_q == '0) begin
            done_q <= 1'b1;
            st_q   <= C_IDLE;
          end else begin
            cur_q <= nxt_addr;
            idx_q <= '0;
            st_q  <= C_FETCH;
          end
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != C_IDLE);
  assign done_o    = done_q;
  assign irq_o     = irq_q;
  assign unavail_o = unav_q;

  // R3: descriptor sequencer and data mover never request together
  a_r3_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_req && mv_req));

  // R1: an idle engine keeps the memory port quiet
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !out_valid_o && !in_ready_o);

  // R9: interrupt only follows an acknowledged write-back
  a_r9_irq_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(st_q == C_WBACK && mem_ack_i));

  // R10: completion leaves the engine idle
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R4: unavailable descriptor stops the walk
  a_r4_unavail_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unavail_o) |-> !busy_o && !$past(mem_we_o));
endmodule

// File: tb/tb_ddma_chain_dma.sv
module tb_ddma_chain_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, soft_rst = 1'b0, start = 1'b0, dir = 1'b0;
  logic [31:0] base_addr = '0, total = '0;
  logic        busy_o, done_o, irq_o, unavail_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        out_valid_o, out_ready = 1'b0;
  logic [31:0] out_data_o;
  logic        in_valid = 1'b0, in_ready_o;
  logic [31:0] in_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  ddma_chain_dma dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .soft_rst_i(soft_rst),
    .start_i(start), .dir_i(dir), .base_addr_i(base_addr), .total_bytes_i(total),
    .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o), .unavail_o(unavail_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_data_o(out_data_o),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data)
  );

  logic [31:0] mem [1024];
  logic [31:0] exp_mem [1024];
  logic [31:0] got_q [$];
  logic [31:0] exp_q [$];
  int errors = 0, checks = 0, cyc = 0;
  int irq_cnt, done_cnt, both_cnt, req_cnt, src_idx;
  int e_irq;
  bit e_done, e_unav, first_seen, in_pend, prev_stall, sr_edge;
  logic [31:0] first_addr, prev_data;

  function automatic int unsigned wi(input logic [31:0] a);
    return int'(a[11:2]);
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 + 32'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    sr_edge <= soft_rst;
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<190000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // memory model, stream endpoints and pulse monitors
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req_o && ($urandom % 4 != 0)) begin
      mem_ack = 1'b1;
      if (mem_we_o) mem[wi(mem_addr_o)] = mem_wdata_o;
      else          mem_rdata = mem[wi(mem_addr_o)];
    end
    if (mem_req_o) begin
      req_cnt++;
      if (!first_seen) begin first_seen = 1; first_addr = mem_addr_o; end
    end
    if (prev_stall && !sr_edge)
      chk(out_valid_o && out_data_o == prev_data, "R13", "stalled word held",
          out_data_o, prev_data);
    out_ready = ($urandom % 3 != 0);
    if (out_valid_o && out_ready) got_q.push_back(out_data_o);
    prev_stall = out_valid_o && !out_ready;
    prev_data  = out_data_o;
    if (in_pend && !sr_edge) src_idx++;
    in_valid = ($urandom % 3 != 0);
    in_data  = pat(src_idx);
    in_pend  = in_valid && in_ready_o;
    if (irq_o) irq_cnt++;
    if (done_o) done_cnt++;
    if (irq_o && done_o) both_cnt++;
  end

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
    mem[wi(a)] = w0; mem[wi(a+4)] = w1; mem[wi(a+8)] = w2; mem[wi(a+12)] = w3;
  endtask

  task automatic move_buf(input bit d, input logic [31:0] a, input int n, inout int src);
    for (int i = 0; i < n; i++) begin
      if (!d) exp_q.push_back(exp_mem[wi(a + 32'(4*i))]);
      else begin exp_mem[wi(a + 32'(4*i))] = pat(src); src++; end
    end
  endtask

  task automatic predict(input bit d, input logic [31:0] b, input logic [31:0] tot);
    logic [31:0] cur, w0, w1, w2, w3, rem, sz, by;
    int src;
    cur = b; rem = tot; src = 0;
    e_irq = 0; e_done = 0; e_unav = 0; exp_q.delete();
    for (int it = 0; it < 64; it++) begin
      w0 = exp_mem[wi(cur)];
      if (!w0[31]) begin e_unav = 1; break; end
      w1 = exp_mem[wi(cur+4)]; w2 = exp_mem[wi(cur+8)]; w3 = exp_mem[wi(cur+12)];
      sz = {19'd0, w1[12:0]};
      by = (rem < sz) ? rem : sz;
      move_buf(d, w2, int'((by + 3) / 4), src);
      rem = rem - by;
      if (!w0[4]) begin
        sz = {19'd0, w1[25:13]};
        by = (rem < sz) ? rem : sz;
        move_buf(d, w3, int'((by + 3) / 4), src);
        rem = rem - by;
      end
      exp_mem[wi(cur)] = w0 & 32'h7FFF_FFFF;
      if (!w0[1]) e_irq++;
      if (w0[2] || rem == 0) begin e_done = 1; break; end
      cur = w0[4] ? w3 : (w0[5] ? b : cur + 16);
    end
  endtask

  task automatic run_case(input string name, input bit d, input logic [31:0] b,
                          input logic [31:0] tot);
    int bad, bad_i;
    bit fin;
    for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
    predict(d, b, tot);
    @(negedge clk);
    got_q.delete();
    irq_cnt = 0; done_cnt = 0; both_cnt = 0; req_cnt = 0; src_idx = 0;
    first_seen = 0;
    dir = d; base_addr = b; total = tot; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fin = 0;
    for (int k = 0; k < 20000; k++) begin
      if (done_cnt > 0 || unavail_o) begin fin = 1; break; end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(fin, "R10", {name, " finished"}, 32'(fin), 1);
    chk(first_addr == b, "R3", {name, " first fetch address"}, first_addr, b);
    chk(done_cnt == int'(e_done), "R10", {name, " done pulses"}, 32'(done_cnt), 32'(e_done));
    chk(unavail_o == e_unav, "R4", {name, " unavail"}, 32'(unavail_o), 32'(e_unav));
    chk(irq_cnt == e_irq, "R9", {name, " irq pulses"}, 32'(irq_cnt), 32'(e_irq));
    chk(!busy_o, "R10", {name, " idle after"}, 32'(busy_o), 0);
    bad = 0;
    if (got_q.size() != exp_q.size()) bad = 1;
    else for (int i = 0; i < got_q.size(); i++) if (got_q[i] !== exp_q[i]) bad = 1;
    chk(bad == 0, "R11", {name, " out stream words (R5 R6 R7)"},
        32'(got_q.size()), 32'(exp_q.size()));
    bad = 0; bad_i = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== exp_mem[i] && bad == 0) begin bad = 1; bad_i = i; end
    chk(bad == 0, "R8", {name, " memory image (R6 R7 R11)"}, mem[bad_i], exp_mem[bad_i]);
    if (!fin) begin
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    end
  endtask

  task automatic fill_random;
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
  endtask

  initial begin
    logic [31:0] w0, w3, a;
    int n;
    bit ch, dc;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
    // R1 during and after reset
    chk(!busy_o && !done_o && !irq_o && !unavail_o && !mem_req_o && !out_valid_o && !in_ready_o,
        "R1", "outputs in reset", {25'd0, busy_o, done_o, irq_o, unavail_o, mem_req_o,
        out_valid_o, in_ready_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o && !out_valid_o && !in_ready_o, "R1", "outputs after reset",
        {28'd0, busy_o, mem_req_o, out_valid_o, in_ready_o}, 0);

    // R2: start ignored while disabled
    fill_random();
    put_desc(32'h0, 32'h8000_0004, 32'd16, 32'h400, 32'h0);
    req_cnt = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy_o && req_cnt == 0, "R2", "no activity when disabled", 32'(req_cnt), 0);
    enable = 1'b1;

    // R5 chained list memory->stream, last entry irq coincides with done
    fill_random();
    put_desc(32'h40, 32'h8000_001A, 32'd16, 32'h400, 32'h50);
    put_desc(32'h50, 32'h8000_0012, 32'd16, 32'h500, 32'h60);
    put_desc(32'h60, 32'h8000_0004, 32'd10, 32'h600, 32'h0);
    run_case("R5 chained read", 1'b0, 32'h40, 32'd1000);
    chk(both_cnt == 1, "R9", "irq and done same cycle", 32'(both_cnt), 1);

    // R11 same list, stream->memory
    fill_random();
    put_desc(32'h40, 32'h8000_001A, 32'd16, 32'h400, 32'h50);
    put_desc(32'h50, 32'h8000_0012, 32'd16, 32'h500, 32'h60);
    put_desc(32'h60, 32'h8000_0004, 32'd10, 32'h600, 32'h0);
    run_case("R11 chained write", 1'b1, 32'h40, 32'd1000);

    // R7 byte limit ends the walk early
    fill_random();
    put_desc(32'h0, 32'h8000_0010, 32'd32, 32'h400, 32'h10);
    put_desc(32'h10, 32'h8000_0010, 32'd32, 32'h500, 32'h20);
    put_desc(32'h20, 32'h8000_0010, 32'd32, 32'h600, 32'h0);
    run_case("R7 byte limit", 1'b0, 32'h0, 32'd40);

    // R6 two buffers, sequential then ring end back to a returned descriptor
    fill_random();
    put_desc(32'h80, 32'h8000_0000, 32'd8 | (32'd12 << 13), 32'h400, 32'h480);
    put_desc(32'h90, 32'h8000_0022, 32'd4, 32'h500, 32'h580);
    run_case("R6 ring", 1'b0, 32'h80, 32'd1000);

    // R4 descriptor not owned
    fill_random();
    put_desc(32'h20, 32'h0000_0014, 32'd16, 32'h400, 32'h0);
    run_case("R4 not owned", 1'b1, 32'h20, 32'd64);
    @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk(!unavail_o, "R12", "soft reset clears unavail", 32'(unavail_o), 0);

    // R12 soft reset mid transfer
    fill_random();
    put_desc(32'h0, 32'h8000_0010, 32'd400, 32'h400, 32'h10);
    put_desc(32'h10, 32'h8000_0004, 32'd400, 32'h800, 32'h0);
    dir = 1'b0; base_addr = 32'h0; total = 32'd2000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (25) @(negedge clk);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk(!busy_o && !mem_req_o && !out_valid_o && !in_ready_o, "R12", "idle after soft reset",
        {28'd0, busy_o, mem_req_o, out_valid_o, in_ready_o}, 0);
    repeat (3) @(negedge clk);

    // random chains
    for (int t = 0; t < 30; t++) begin
      fill_random();
      n = 1 + int'($urandom % 4);
      a = 32'(16 * ($urandom % 4));
      for (int i = 0; i < n; i++) begin
        ch = $urandom % 2; dc = $urandom % 2;
        if (i == n - 1) begin ch = 0; dc = 0; end
        w0 = 32'h8000_0000 | (32'(ch) << 4) | (32'(dc) << 1) |
             (32'(i == n - 1) << 2) | (32'(i == 0) << 3);
        w3 = ch ? a + 32'(16 * (i + 1)) : 32'h480 + 32'(256 * i);
        put_desc(a + 32'(16 * i), w0, ($urandom % 41) | (($urandom % 41) << 13),
                 32'h400 + 32'(256 * i), w3);
      end
      run_case("R7 random", bit'($urandom % 2), a, $urandom % 200);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule